// File: doc/BRIEF.md
# Segmented Data Address Extender

This block sits between an 8-bit data-memory address source (an instruction operand or a pointer) and the physical data memory. It keeps an 8-bit segment register. When the top bit of the incoming address is clear, the lower 128-byte window is relocated into one of 256 segments. The physical address is then the segment value, a zero bit and the low seven address bits. When the top bit is set, the address reaches the upper 128-byte window unchanged. That window is therefore visible whatever the segment holds.

For every access the block also classifies the target as implemented RAM, the register-file bytes, the segment register itself, the peripheral/control range, or an unimplemented hole. From that class it gates the memory enables and selects the read data. A hole reads back as all ones and drops writes. The segment register lives at address 0xFF and is read and written through the same access port. A write to it affects only later accesses.

Top module: `seg_addr_ext`

## Requirements
- R1: An access with address bit 7 set yields physical address 0x00 followed by the 8 address bits, whatever the segment value.
- R2: An access with address bit 7 clear yields physical address {segment, 1'b0, addr[6:0]}.
- R3: After reset the segment register reads 0x00, so lower addresses map to 0x0000..0x007F.
- R4: A valid write to address 0xFF loads the segment register at the clock edge that ends the access. The access that performs the write is translated with the old value, and the next access uses the new one.
- R5: A read of address 0xFF returns the segment register on rd_data, flags region bit 2, and keeps mem_en and mem_we low.
- R6: In segment 0, offsets 0x00..0x6F are RAM (region bit 0). Offsets 0x70..0x7F are a hole (region bit 4).
- R7: Segments 1..EXTRA_SEGS (default 1) are RAM over all 128 offsets. Any higher segment is a hole over its whole lower window.
- R8: Addresses 0xF0..0xFE are register-file bytes (region bit 1) and enable the memory.
- R9: Addresses 0x80..0xEF are the peripheral range (region bit 3). They enable the memory and return mem_rdata.
- R10: A hole access returns 0xFF on rd_data and keeps mem_en and mem_we low, so writes to it are dropped.
- R11: A write-enabled cycle without acc_valid leaves the segment register unchanged.
- R12: The region output is one-hot during a valid access and zero when no access is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 8 | Logical data address |
| acc_we | input | 1 | Access is a write |
| acc_wdata | input | 8 | Write data |
| mem_rdata | input | 8 | Read data from the physical memory |
| phys_addr | output | 16 | Translated physical address |
| mem_en | output | 1 | Memory access enable (RAM, register file, peripheral) |
| mem_we | output | 1 | Memory write enable |
| region | output | 5 | One-hot class: 0 RAM, 1 register file, 2 segment reg, 3 peripheral, 4 hole |
| rd_data | output | 8 | Read data returned to the requester |

## Verification
The bench targets the edges of the RAM map. It probes offsets 0x6F against 0x70 in segment 0, both ends of segment 1, and segment 2. A design with an off-by-one limit would flag RAM as a hole or let a write land in empty space. It writes the segment register and checks that the upper window keeps its zero-extended address under segment 0xFF. A design that extended every address would put those registers out of reach. It also checks the one-cycle write latency and writes issued without valid. A register that updated early, or on any write enable, would move the window under the wrong access.

// File: rtl/seg_ext_pkg.sv
package seg_ext_pkg;
  localparam int ADDR_W  = 8;
  localparam int SEG_W   = 8;
  localparam int PHYS_W  = SEG_W + ADDR_W;
  localparam int LOW_W   = ADDR_W - 1;
  localparam int NREGION = 5;

  localparam int RG_RAM    = 0;
  localparam int RG_REGF   = 1;
  localparam int RG_SEG    = 2;
  localparam int RG_PERIPH = 3;
  localparam int RG_HOLE   = 4;
endpackage

// File: rtl/seg_reg.sv
module seg_reg
  import seg_ext_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_data,
  output logic [SEG_W-1:0] seg_q
);
  logic [SEG_W-1:0] seg_d;

  always_comb begin
    seg_d = seg_q;
    if (wr_en) seg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= seg_d;
  end

  // R4: a write lands in the following cycle
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_q == $past(wr_data));
  // R11: no write, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(seg_q));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import seg_ext_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEG_W-1:0]  seg,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    if (addr[ADDR_W-1]) phys = {{SEG_W{1'b0}}, addr};
    else                phys = {seg, 1'b0, addr[LOW_W-1:0]};
  end
endmodule

// File: rtl/region_decode.sv
module region_decode
  import seg_ext_pkg::*;
#(
  parameter int BASE_RAM_LAST = 'h6F,
  parameter int EXTRA_SEGS    = 1,
  parameter int REGF_BASE     = 'hF0
) (
  input  logic               valid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SEG_W-1:0]   seg,
  output logic [NREGION-1:0] region
);
  localparam logic [ADDR_W-1:0] SEGREG_ADDR = {ADDR_W{1'b1}};
  localparam logic [LOW_W-1:0]  BASE_LAST   = LOW_W'(BASE_RAM_LAST);
  localparam logic [SEG_W-1:0]  EXTRA_TOP   = SEG_W'(EXTRA_SEGS);
  localparam logic [ADDR_W-1:0] REGF_LO     = ADDR_W'(REGF_BASE);

  always_comb begin
    region = '0;
    if (valid) begin
      if (addr[ADDR_W-1]) begin
        if (addr == SEGREG_ADDR)  region[RG_SEG]    = 1'b1;
        else if (addr >= REGF_LO) region[RG_REGF]   = 1'b1;
        else                      region[RG_PERIPH] = 1'b1;
      end else if (seg == '0) begin
        if (addr[LOW_W-1:0] <= BASE_LAST) region[RG_RAM]  = 1'b1;
        else                              region[RG_HOLE] = 1'b1;
      end else begin
        if (seg <= EXTRA_TOP) region[RG_RAM]  = 1'b1;
        else                  region[RG_HOLE] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_addr_ext.sv
module seg_addr_ext
  import seg_ext_pkg::*;
#(
  parameter int BASE_RAM_LAST = 'h6F,
  parameter int EXTRA_SEGS    = 1,
  parameter int REGF_BASE     = 'hF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                acc_we,
  input  logic [SEG_W-1:0]    acc_wdata,
  input  logic [7:0]          mem_rdata,
  output logic [PHYS_W-1:0]   phys_addr,
  output logic                mem_en,
  output logic                mem_we,
  output logic [NREGION-1:0]  region,
  output logic [7:0]          rd_data
);
  logic [SEG_W-1:0] seg_q;
  logic             seg_wr;

  assign seg_wr = acc_we & region[RG_SEG];

  seg_reg u_seg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr),
    .wr_data (acc_wdata),
    .seg_q   (seg_q)
  );

  addr_xlate u_xl (
    .addr (acc_addr),
    .seg  (seg_q),
    .phys (phys_addr)
  );

  region_decode #(
    .BASE_RAM_LAST (BASE_RAM_LAST),
    .EXTRA_SEGS    (EXTRA_SEGS),
    .REGF_BASE     (REGF_BASE)
  ) u_rd (
    .valid  (acc_valid),
    .addr   (acc_addr),
    .seg    (seg_q),
    .region (region)
  );

  always_comb begin
    mem_en = region[RG_RAM] | region[RG_REGF] | region[RG_PERIPH];
    mem_we = mem_en & acc_we;
    if (region[RG_SEG])       rd_data = seg_q;
    else if (region[RG_HOLE]) rd_data = 8'hFF;
    else                      rd_data = mem_rdata;
  end

  // R12: region class is one-hot for a valid access
  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones(region) == 1);
  // R10: holes never reach memory and read as ones
  a_r10_hole: assert property (@(posedge clk) disable iff (!rst_n)
    region[RG_HOLE] |-> (!mem_en && !mem_we && rd_data == 8'hFF));
  // R1: upper window is never extended
  a_r1_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[ADDR_W-1]) |-> phys_addr[PHYS_W-1:ADDR_W] == '0);
  // R5: segment register access stays off the memory
  a_r5_seg_private: assert property (@(posedge clk) disable iff (!rst_n)
    region[RG_SEG] |-> (!mem_en && rd_data == seg_q));
endmodule

// File: tb/sim_seg_addr_ext.sv
module sim_seg_addr_ext;
  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic [7:0]  acc_addr;
  logic        acc_we;
  logic [7:0]  acc_wdata;
  logic [7:0]  mem_rdata;
  logic [15:0] phys_addr;
  logic        mem_en;
  logic        mem_we;
  logic [4:0]  region;
  logic [7:0]  rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [4:0] K_RAM  = 5'b00001;
  localparam logic [4:0] K_REGF = 5'b00010;
  localparam logic [4:0] K_SEG  = 5'b00100;
  localparam logic [4:0] K_PER  = 5'b01000;
  localparam logic [4:0] K_HOLE = 5'b10000;

  seg_addr_ext u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .mem_rdata(mem_rdata),
    .phys_addr(phys_addr), .mem_en(mem_en), .mem_we(mem_we),
    .region(region), .rd_data(rd_data)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit v, input logic [7:0] a, input bit w, input logic [7:0] d);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_we = w; acc_wdata = d;
    #1;
  endtask

  task automatic t_reset;
    access(1, 8'hFF, 0, 0);
    chk("R3 seg reset", rd_data, 8'h00);
    chk("R5 seg region", region, K_SEG);
    chk("R5 seg no mem_en", mem_en, 0);
    access(1, 8'h10, 0, 0);
    chk("R3 phys seg0", phys_addr, 16'h0010);
    chk("R6 ram region", region, K_RAM);
    chk("R6 ram data", rd_data, 8'hA5);
  endtask

  task automatic t_seg0_edges;
    access(1, 8'h6F, 1, 8'h11);
    chk("R6 0x6F ram", region, K_RAM);
    chk("R6 0x6F we", mem_we, 1);
    access(1, 8'h70, 1, 8'h11);
    chk("R6 0x70 hole", region, K_HOLE);
    chk("R10 hole no we", mem_we, 0);
    chk("R10 hole no en", mem_en, 0);
    chk("R10 hole reads ones", rd_data, 8'hFF);
  endtask

  task automatic t_upper;
    access(1, 8'h85, 0, 0);
    chk("R1 phys upper", phys_addr, 16'h0085);
    chk("R9 periph region", region, K_PER);
    chk("R9 periph data", rd_data, 8'hA5);
    chk("R9 periph en", mem_en, 1);
    access(1, 8'hEF, 0, 0);
    chk("R9 0xEF periph", region, K_PER);
    access(1, 8'hF0, 1, 8'h22);
    chk("R8 0xF0 regfile", region, K_REGF);
    chk("R8 regfile we", mem_we, 1);
    access(1, 8'hFE, 0, 0);
    chk("R8 0xFE regfile", region, K_REGF);
  endtask

  task automatic t_seg1;
    access(1, 8'hFF, 1, 8'h01);
    chk("R4 write cycle no mem_we", mem_we, 0);
    chk("R4 write cycle old value", rd_data, 8'h00);
    access(1, 8'h20, 0, 0);
    chk("R4 new seg used", phys_addr, 16'h0120);
    chk("R2 phys seg1", phys_addr, 16'h0120);
    chk("R7 seg1 ram", region, K_RAM);
    access(1, 8'h7F, 0, 0);
    chk("R7 seg1 top ram", region, K_RAM);
    chk("R2 phys 0x17F", phys_addr, 16'h017F);
    access(1, 8'h00, 0, 0);
    chk("R7 seg1 bottom ram", region, K_RAM);
    access(1, 8'hFF, 0, 0);
    chk("R5 seg readback", rd_data, 8'h01);
  endtask

  task automatic t_high_seg;
    access(1, 8'hFF, 1, 8'h02);
    access(1, 8'h00, 1, 8'h55);
    chk("R7 seg2 hole", region, K_HOLE);
    chk("R2 phys seg2", phys_addr, 16'h0200);
    chk("R10 seg2 write dropped", mem_we, 0);
    access(1, 8'hFF, 1, 8'hFF);
    access(1, 8'h7F, 0, 0);
    chk("R2 phys segFF", phys_addr, 16'hFF7F);
    chk("R10 segFF reads ones", rd_data, 8'hFF);
    access(1, 8'hC0, 0, 0);
    chk("R1 upper under segFF", phys_addr, 16'h00C0);
    chk("R9 upper visible", region, K_PER);
  endtask

  task automatic t_novalid;
    access(0, 8'hFF, 1, 8'h33);
    chk("R12 idle region zero", region, 0);
    chk("R12 idle no mem_en", mem_en, 0);
    access(1, 8'hFF, 0, 0);
    chk("R11 seg unchanged", rd_data, 8'hFF);
  endtask

  initial begin
    rst_n = 0; acc_valid = 0; acc_addr = 0; acc_we = 0; acc_wdata = 0;
    mem_rdata = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_seg0_edges();
    t_upper();
    t_seg1();
    t_high_seg();
    t_novalid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule